// File: doc/BRIEF.md
# Peak-Power Injection Admission Controller

This block sits between a traffic source and its network interface. It keeps the power that admitted traffic commits to the on-chip network under a fixed peak budget. The budget is held as a pool of power credits. Each class of traffic is controlled in its own way. A real-time connection is controlled once, at setup. Its request carries a bandwidth figure and a cost coefficient. The request is granted and charged if the rounded-up cost fits the pool and a connection slot is free. Otherwise it is refused with a single-cycle pulse and is not kept. After a connection is granted, nothing in this block ever holds back its packets.

A best-effort packet is charged separately. Its cost grows with the Manhattan hop distance between its source and destination mesh nodes, its length in flits and a per-flit-hop coefficient. A packet whose cost does not fit stays stalled at the head of the source until enough credit has come back. Credit comes back in two ways. A teardown strobe names a connection slot, and the block refunds the cost it stored for that slot. A delivery acknowledgement carries back the cost that the packet was charged. All admission decisions are combinational within the cycle of the request. The credit pool changes at the following clock edge.

Top module: `pwr_admit_ctrl`

## Requirements
- R1: After reset, `credits` equals BUDGET (1000 by default), `err` is 0, all 8 connection slots are free, and no grant or release is signalled.
- R2: The cost of a real-time request is ceil(rt_bw × rt_coef / 16). `rt_grant` is high in the request cycle when that cost is ≤ `credits` and a slot is free. On the next edge `credits` drops by exactly that cost.
- R3: A real-time request whose cost exceeds `credits`, or that arrives while all 8 slots are in use, raises `rt_reject` for that cycle only. The credits and the slot table do not change, and the request is not retried.
- R4: `rt_id` on a grant is the lowest-numbered free slot. That slot then stays occupied until it is torn down.
- R5: A teardown (`rt_close` with `rt_close_id`) of an occupied slot refunds the cost stored for that slot at the next edge and frees the slot.
- R6: The cost of a best-effort packet, shown on `be_cost`, is (|sx−dx| + |sy−dy| + 1) × be_flits × be_coef. `be_go` is high when that cost is ≤ the credit that is left, and the cost is charged at the edge.
- R7: A best-effort packet that does not fit holds `be_stall` high with `credits` unchanged. It is released in the first cycle after returned credit makes it fit.
- R8: When a real-time request and a best-effort packet arrive in the same cycle, the real-time request is decided first. The packet sees only the credit left after the real-time charge.
- R9: `be_ack` returns `be_ack_cost` to the pool at the next edge.
- R10: A refund that would raise `credits` above BUDGET leaves `credits` at BUDGET and sets `err`. A teardown of a free slot also sets `err`. `err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rt_req | input | 1 | Real-time connection request, valid for one cycle |
| rt_bw | input | 8 | Requested bandwidth |
| rt_coef | input | 8 | Power per unit of bandwidth, 4 fraction bits |
| rt_grant | output | 1 | Request admitted this cycle |
| rt_reject | output | 1 | Request refused this cycle |
| rt_id | output | 3 | Slot assigned on a grant |
| rt_close | input | 1 | Connection teardown strobe |
| rt_close_id | input | 3 | Slot being torn down |
| be_req | input | 1 | Best-effort packet waiting at the head |
| be_sx | input | 3 | Source X coordinate |
| be_sy | input | 3 | Source Y coordinate |
| be_dx | input | 3 | Destination X coordinate |
| be_dy | input | 3 | Destination Y coordinate |
| be_flits | input | 4 | Packet length in flits |
| be_coef | input | 4 | Energy per flit per hop |
| be_go | output | 1 | Packet may be injected this cycle |
| be_stall | output | 1 | Packet held back for lack of credit |
| be_cost | output | 12 | Computed cost of the head packet |
| be_ack | input | 1 | Delivery acknowledgement |
| be_ack_cost | input | 12 | Cost returned by the acknowledgement |
| credits | output | 10 | Credits currently available |
| err | output | 1 | Sticky over-return error |

## Verification
Real-time costs are tested with exact multiples of 16, with products that need rounding up, with a zero bandwidth, with a cost equal to the full budget and with a cost one step above it. These cases separate the ceiling from truncation and show that the fit test uses ≤ rather than <. Best-effort costs are tested with routes that differ in direction along each axis, a route to the packet's own node, the mesh diagonal and a zero-flit packet. These cases separate the absolute-difference hop count and the +1 term from near misses. Directed sequences fill all slots to show lowest-slot allocation and refusal when the table is full. They pair a real-time request with a packet in the same cycle to show the order of priority, keep a packet stalled until a teardown frees credit, and over-return credit to show saturation and the sticky error.

// File: rtl/pwr_admit_ctrl.sv
module pwr_admit_ctrl #(
  parameter int BUDGET = 1000,
  parameter int NCONN  = 8,
  parameter int BW_W   = 8,
  parameter int RTC_W  = 8,
  parameter int FRAC   = 4,
  parameter int CRD_W  = 3,
  parameter int FLIT_W = 4,
  parameter int BEC_W  = 4,
  localparam int CW = $clog2(BUDGET + 1),
  localparam int IW = $clog2(NCONN),
  localparam int PW = CRD_W + 1 + FLIT_W + BEC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rt_req,
  input  logic [BW_W-1:0]   rt_bw,
  input  logic [RTC_W-1:0]  rt_coef,
  output logic              rt_grant,
  output logic              rt_reject,
  output logic [IW-1:0]     rt_id,
  input  logic              rt_close,
  input  logic [IW-1:0]     rt_close_id,
  input  logic              be_req,
  input  logic [CRD_W-1:0]  be_sx,
  input  logic [CRD_W-1:0]  be_sy,
  input  logic [CRD_W-1:0]  be_dx,
  input  logic [CRD_W-1:0]  be_dy,
  input  logic [FLIT_W-1:0] be_flits,
  input  logic [BEC_W-1:0]  be_coef,
  output logic              be_go,
  output logic              be_stall,
  output logic [PW-1:0]     be_cost,
  input  logic              be_ack,
  input  logic [PW-1:0]     be_ack_cost,
  output logic [CW-1:0]     credits,
  output logic              err
);
  localparam int RW = BW_W + RTC_W;
  localparam int HW = CRD_W + 1;
  localparam int SW = RW + PW + 2;

  logic [CW-1:0]    avail_q;
  logic             err_q;
  logic [NCONN-1:0] live_q;
  logic [CW-1:0]    slot_cost_q [NCONN];

  logic [RW:0] rt_cost;
  assign rt_cost = ((RW+1)'(rt_bw) * (RW+1)'(rt_coef) + (RW+1)'((1 << FRAC) - 1)) >> FRAC;

  logic          have_free;
  logic [IW-1:0] free_id;
  always_comb begin
    have_free = 1'b0;
    free_id   = '0;
    for (int i = NCONN - 1; i >= 0; i--) begin
      if (!live_q[i]) begin
        have_free = 1'b1;
        free_id   = IW'(i);
      end
    end
  end

  assign rt_grant  = rt_req & have_free & (SW'(rt_cost) <= SW'(avail_q));
  assign rt_reject = rt_req & ~rt_grant;
  assign rt_id     = free_id;

  logic [SW-1:0] left;
  assign left = SW'(avail_q) - (rt_grant ? SW'(rt_cost) : '0);

  logic [CRD_W-1:0] ax, ay;
  assign ax = (be_sx >= be_dx) ? be_sx - be_dx : be_dx - be_sx;
  assign ay = (be_sy >= be_dy) ? be_sy - be_dy : be_dy - be_sy;
  assign be_cost  = PW'(HW'(ax) + HW'(ay) + HW'(1)) * PW'(be_flits) * PW'(be_coef);
  assign be_go    = be_req & (SW'(be_cost) <= left);
  assign be_stall = be_req & ~be_go;

  logic          close_ok, bad_close, over;
  logic [SW-1:0] after;
  assign close_ok  = rt_close & live_q[rt_close_id];
  assign bad_close = rt_close & ~live_q[rt_close_id];
  assign after = left - (be_go ? SW'(be_cost) : '0)
               + (close_ok ? SW'(slot_cost_q[rt_close_id]) : '0)
               + (be_ack ? SW'(be_ack_cost) : '0);
  assign over = after > SW'(BUDGET);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      avail_q <= CW'(BUDGET);
      err_q   <= 1'b0;
      live_q  <= '0;
    end else begin
      avail_q <= over ? CW'(BUDGET) : CW'(after);
      err_q   <= err_q | over | bad_close;
      if (close_ok) live_q[rt_close_id] <= 1'b0;
      if (rt_grant) live_q[free_id] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rt_grant) slot_cost_q[free_id] <= CW'(rt_cost);
  end

  assign credits = avail_q;
  assign err     = err_q;

  // R1
  credit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    avail_q <= CW'(BUDGET));
  // R2
  rt_charge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rt_grant && !be_go && !rt_close && !be_ack |=>
      SW'(avail_q) == $past(SW'(avail_q) - SW'(rt_cost)));
  // R3
  rt_reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rt_reject && !be_go && !rt_close && !be_ack |=> $stable(avail_q) && $stable(live_q));
  // R6
  be_charge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    be_go && !rt_grant && !rt_close && !be_ack |=>
      SW'(avail_q) == $past(SW'(avail_q) - SW'(be_cost)));
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: tb/pwr_admit_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_admit_ctrl_tb;
  logic clk = 0;
  always #4 clk = ~clk;

  logic rst_n, rt_req, rt_close, be_req, be_ack;
  logic [7:0] rt_bw, rt_coef;
  logic [2:0] rt_close_id, be_sx, be_sy, be_dx, be_dy, rt_id;
  logic [3:0] be_flits, be_coef;
  logic [11:0] be_cost, be_ack_cost;
  logic rt_grant, rt_reject, be_go, be_stall, err;
  logic [9:0] credits;

  pwr_admit_ctrl u_dut (.*);

  int nchk = 0, nbad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    rt_req = 0; rt_close = 0; be_req = 0; be_ack = 0;
  endtask

  // [63] kind (0 rt, 1 be), [62] expected admit, [55:48] bw | {sx,sy},
  // [47:40] coef | {dx,dy}, [39:32] flits, [31:24] be coef, [15:0] cost
  localparam logic [63:0] VEC [14] = '{
    64'h400A_1000_0000_000A,
    64'h4007_0500_0000_0003,
    64'h00FF_FF00_0000_0000,
    64'h4000_0900_0000_0000,
    64'h4001_0100_0000_0001,
    64'h4064_A000_0000_03E8,
    64'h0064_A100_0000_0000,
    64'hC000_3202_0500_003C,
    64'hC077_0001_0100_000F,
    64'hC044_4403_0700_0015,
    64'hC026_5104_0300_006C,
    64'h8007_700F_0F00_0D2F,
    64'hC010_000F_0F00_01C2,
    64'hC033_6600_0900_0000
  };

  initial begin
    #(8 * 200000);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    idle();
    rt_bw = 0; rt_coef = 0; rt_close_id = 0; be_sx = 0; be_sy = 0; be_dx = 0; be_dy = 0;
    be_flits = 0; be_coef = 0; be_ack_cost = 0;
    rst_n = 0;
    step(); step();
    rst_n = 1;
    #1;
    check(credits == 1000, "R1 credits", credits, 1000);
    check(err == 0, "R1 err", err, 0);
    check(rt_grant == 0 && be_go == 0, "R1 idle", rt_grant, 0);

    for (int v = 0; v < 14; v++) begin
      logic [63:0] e;
      int ex;
      e = VEC[v];
      ex = int'(e[15:0]);
      if (!e[63]) begin
        rt_req = 1; rt_bw = e[55:48]; rt_coef = e[47:40];
        #1;
        check(rt_grant == e[62], e[62] ? "R2 grant" : "R3 reject", rt_grant, e[62]);
        check(rt_reject == !e[62], "R3 reject pulse", rt_reject, !e[62]);
        step(); idle();
        check(credits == 1000 - (e[62] ? ex : 0), "R2 charge", credits, 1000 - (e[62] ? ex : 0));
        if (e[62]) begin
          rt_close = 1; rt_close_id = 0;
          step(); idle();
          check(credits == 1000, "R5 refund", credits, 1000);
        end
      end else begin
        be_req = 1; be_sx = e[54:52]; be_sy = e[50:48]; be_dx = e[46:44]; be_dy = e[42:40];
        be_flits = e[35:32]; be_coef = e[27:24];
        #1;
        check(be_cost == ex, "R6 cost", be_cost, ex);
        check(be_go == e[62], e[62] ? "R6 go" : "R7 stall", be_go, e[62]);
        step(); idle();
        check(credits == 1000 - (e[62] ? ex : 0), "R6 charge", credits, 1000 - (e[62] ? ex : 0));
        if (e[62]) begin
          be_ack = 1; be_ack_cost = 12'(ex);
          step(); idle();
          check(credits == 1000, "R9 ack", credits, 1000);
        end
      end
    end

    // R4: fill all slots, lowest free id first
    for (int k = 0; k < 8; k++) begin
      rt_req = 1; rt_bw = 1; rt_coef = 16;
      #1;
      check(rt_grant && rt_id == 3'(k), "R4 slot order", rt_id, k);
      step();
    end
    #1;
    check(rt_reject == 1, "R3 table full", rt_reject, 1);
    step(); idle();
    check(credits == 992, "R3 full no charge", credits, 992);
    rt_close = 1; rt_close_id = 3;
    step(); idle();
    check(credits == 993, "R5 close slot", credits, 993);
    rt_req = 1; rt_bw = 1; rt_coef = 16;
    #1;
    check(rt_grant && rt_id == 3, "R4 reuse freed slot", rt_id, 3);
    step(); idle();
    for (int k = 0; k < 8; k++) begin
      rt_close = 1; rt_close_id = 3'(k);
      step();
    end
    idle();
    check(credits == 1000, "R5 all refunded", credits, 1000);
    check(err == 0, "R10 no false err", err, 0);

    // R8: same cycle, real-time decided first; packet cost 60 fits after 938
    rt_req = 1; rt_bw = 100; rt_coef = 150;
    be_req = 1; be_sx = 0; be_sy = 0; be_dx = 3; be_dy = 2; be_flits = 2; be_coef = 5;
    #1;
    check(rt_grant && be_go, "R8 both fit", {rt_grant, be_go}, 3);
    step(); idle();
    check(credits == 2, "R8 both charged", credits, 2);
    rt_close = 1; rt_close_id = 0; be_ack = 1; be_ack_cost = 60;
    step(); idle();
    check(credits == 1000, "R9 restore", credits, 1000);
    // cost 944 leaves 56, packet 60 must stall
    rt_req = 1; rt_bw = 100; rt_coef = 151; be_req = 1;
    #1;
    check(rt_grant && !be_go && be_stall, "R8 rt wins", be_go, 0);
    step(); rt_req = 0;
    #1;
    check(be_stall == 1 && credits == 56, "R7 still stalled", credits, 56);
    rt_close = 1; rt_close_id = 0;
    #1;
    check(be_go == 0, "R7 refund not same cycle", be_go, 0);
    step(); rt_close = 0;
    #1;
    check(be_go == 1 && credits == 1000, "R7 released", be_go, 1);
    step(); idle();
    check(credits == 940, "R7 charged on release", credits, 940);
    be_ack = 1; be_ack_cost = 60;
    step(); idle();

    // R10: over-return saturates and is sticky
    be_ack = 1; be_ack_cost = 5;
    step(); idle();
    check(credits == 1000, "R10 saturate", credits, 1000);
    check(err == 1, "R10 err set", err, 1);
    step();
    check(err == 1, "R10 err sticky", err, 1);
    rst_n = 0; step(); rst_n = 1;
    #1;
    check(err == 0, "R1 err cleared", err, 0);
    rt_close = 1; rt_close_id = 5;
    step(); idle();
    check(err == 1 && credits == 1000, "R10 idle slot close", err, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule